// File: doc/BRIEF.md
# Masked Time Alarm Comparator

This block watches the running time of day (seconds, minutes, hours and day of month, all BCD) and raises an alarm when the time matches a programmed alarm setting. Four alarm setting registers each hold one BCD field. The top bit of each register is a mask bit, and the four mask bits together select how often the alarm repeats: every second, or when one, two, three or all four fields agree.

A match is only evaluated on the one-second tick, which arrives after the time fields have already advanced. A match sets a sticky alarm flag. If the alarm interrupt enable is set, the match also drives the shared active-low interrupt output. The interrupt is released as soon as software starts an access to the flags register, and the flag is cleared when that access ends. While the system runs from its backup supply, a second enable must also be set before the alarm can drive the interrupt. Both enables are cleared on the transition back to main power, but a match in that window still sets the flag so that software can see it later. The interrupt pin is shared with a watchdog source, and the two are ORed.

Top module: `tod_alarm`

## Requirements
- R1: Register select codes are 0 = seconds alarm, 1 = minutes alarm, 2 = hours alarm, 3 = date alarm, 4 = control. Bit 7 of each alarm register is its mask bit; the mask vector is {date, hours, minutes, seconds} = m3..m0. Patterns select the rate: 1111 every tick, 1110 seconds equal, 1100 seconds and minutes equal, 1000 seconds, minutes and hours equal, 0000 all four fields equal. Seconds and minutes compare bits 6:0, hours and date compare bits 5:0.
- R2: Any other mask pattern behaves as 1111 (every tick matches).
- R3: The flag output rises in the cycle after a tick whose time matches; without a tick, matching time never sets the flag.
- R4: Control bit 7 is the alarm interrupt enable. With it set, a matching tick drives the interrupt low in the cycle after the tick; with it clear, the flag sets and the interrupt stays high.
- R5: The interrupt goes high in the cycle after the flags-access strobe first rises; the flag stays set while the strobe is high and clears in the cycle after the strobe falls.
- R6: While the backup indicator is high, a match drives the interrupt only when control bit 5 (backup enable) and bit 7 are both set.
- R7: A falling edge of the backup indicator clears both enable bits; a later match still sets the flag but leaves the interrupt high.
- R8: The interrupt output is low whenever the watchdog request input is high, regardless of the alarm state.
- R9: After reset the flag is low, the interrupt is high, and all setting registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second tick, time fields already updated |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hour_i | input | 6 | Current hours, BCD 24 h |
| date_i | input | 6 | Current day of month, BCD |
| reg_we_i | input | 1 | Setting register write strobe |
| reg_sel_i | input | 3 | Setting register select |
| reg_wdata_i | input | 8 | Setting register write data |
| flag_acc_i | input | 1 | High during a read or write of the flags register |
| backup_i | input | 1 | High while running from the backup supply |
| wdog_req_i | input | 1 | Watchdog interrupt request sharing the pin |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| irq_no | output | 1 | Shared interrupt, active low |

## Verification
A wrongly decoded mask pattern would show as a flag that sets on a tick whose fields do not satisfy the selected rate, or stays low on one that does, visible one cycle after that tick. A stuck interrupt or enable state shows at the interrupt pin in the cycle after the next matching tick, or in the cycle after a flags access begins. The bench sweeps all sixteen mask patterns against all sixteen combinations of agreeing fields, so any decode error surfaces within a few hundred ticks.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  parameter int DW = 8;
  parameter int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_DATE = 3'd3,
    SEL_CTRL = 3'd4
  } reg_sel_e;

  typedef enum logic [2:0] {
    RATE_EVERY,
    RATE_S,
    RATE_MS,
    RATE_HMS,
    RATE_DHMS
  } rate_e;

  localparam int AE_BIT  = 7;
  localparam int ABE_BIT = 5;
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
  import tod_alarm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             pwr_up_i,
  output logic [DW-1:0]    a_sec_o,
  output logic [DW-1:0]    a_min_o,
  output logic [DW-1:0]    a_hour_o,
  output logic [DW-1:0]    a_date_o,
  output logic             ae_o,
  output logic             abe_o
);
  localparam int NREG = 4;
  logic [DW-1:0] set_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) set_q[g] <= '0;
      else if (we_i && sel_i == SEL_W'(g)) set_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_o  <= 1'b0;
      abe_o <= 1'b0;
    end else if (pwr_up_i) begin
      ae_o  <= 1'b0;
      abe_o <= 1'b0;
    end else if (we_i && sel_i == SEL_CTRL) begin
      ae_o  <= wdata_i[AE_BIT];
      abe_o <= wdata_i[ABE_BIT];
    end
  end

  assign a_sec_o  = set_q[0];
  assign a_min_o  = set_q[1];
  assign a_hour_o = set_q[2];
  assign a_date_o = set_q[3];

  AST_PWRUP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_up_i |=> (!ae_o && !abe_o)); // R7
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
(
  input  logic [DW-1:0] a_sec_i,
  input  logic [DW-1:0] a_min_i,
  input  logic [DW-1:0] a_hour_i,
  input  logic [DW-1:0] a_date_i,
  input  logic [6:0]    sec_i,
  input  logic [6:0]    min_i,
  input  logic [5:0]    hour_i,
  input  logic [5:0]    date_i,
  output rate_e         rate_o,
  output logic          hit_o
);
  logic [3:0] mask;
  logic eq_s, eq_m, eq_h, eq_d;

  assign mask = {a_date_i[DW-1], a_hour_i[DW-1], a_min_i[DW-1], a_sec_i[DW-1]};
  assign eq_s = (a_sec_i[6:0]  == sec_i);
  assign eq_m = (a_min_i[6:0]  == min_i);
  assign eq_h = (a_hour_i[5:0] == hour_i);
  assign eq_d = (a_date_i[5:0] == date_i);

  always_comb begin
    unique case (mask)
      4'b1110: rate_o = RATE_S;
      4'b1100: rate_o = RATE_MS;
      4'b1000: rate_o = RATE_HMS;
      4'b0000: rate_o = RATE_DHMS;
      default: rate_o = RATE_EVERY;  // illegal patterns fall back
    endcase
  end

  always_comb begin
    unique case (rate_o)
      RATE_S:    hit_o = eq_s;
      RATE_MS:   hit_o = eq_s & eq_m;
      RATE_HMS:  hit_o = eq_s & eq_m & eq_h;
      RATE_DHMS: hit_o = eq_s & eq_m & eq_h & eq_d;
      default:   hit_o = 1'b1;
    endcase
  end

  always_comb begin
    AST_ILLEGAL_EVERY: assert (!(mask inside {4'b1111, 4'b1110, 4'b1100, 4'b1000, 4'b0000}) -> hit_o); // R2
  end
endmodule

// File: rtl/tod_alarm_irq.sv
module tod_alarm_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic ae_i,
  input  logic abe_i,
  input  logic backup_i,
  input  logic acc_i,
  output logic flag_o,
  output logic irq_o
);
  logic acc_q, fire, irq_en, flag_clr;

  assign fire     = tick_i & hit_i;
  assign irq_en   = ae_i & (~backup_i | abe_i);
  // flag drops only at end of access and only once the irq is released
  assign flag_clr = acc_q & ~acc_i & ~irq_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= 1'b0;
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      acc_q <= acc_i;
      if (fire)          flag_o <= 1'b1;
      else if (flag_clr) flag_o <= 1'b0;
      if (fire && irq_en) irq_o <= 1'b1;
      else if (acc_i)     irq_o <= 1'b0;
    end
  end

  AST_SET_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> flag_o); // R3
  AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !flag_o |=> !flag_o); // R3
  AST_ACC_RELEASES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !fire |=> !irq_o); // R5
  AST_FLAG_HELD_IN_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && flag_o |=> flag_o); // R5
  AST_BACKUP_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && backup_i && !abe_i && !irq_o |=> !irq_o); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o); // R4
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_alarm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [6:0]       sec_i,
  input  logic [6:0]       min_i,
  input  logic [5:0]       hour_i,
  input  logic [5:0]       date_i,
  input  logic             reg_we_i,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic [DW-1:0]    reg_wdata_i,
  input  logic             flag_acc_i,
  input  logic             backup_i,
  input  logic             wdog_req_i,
  output logic             alarm_flag_o,
  output logic             irq_no
);
  logic [DW-1:0] a_sec, a_min, a_hour, a_date;
  logic ae, abe, hit, alarm_irq, backup_q, pwr_up;
  rate_e rate;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) backup_q <= 1'b0;
    else         backup_q <= backup_i;
  end
  assign pwr_up = backup_q & ~backup_i;

  tod_alarm_regs i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .pwr_up_i(pwr_up),
    .a_sec_o(a_sec), .a_min_o(a_min), .a_hour_o(a_hour), .a_date_o(a_date),
    .ae_o(ae), .abe_o(abe)
  );

  tod_alarm_match i_match (
    .a_sec_i(a_sec), .a_min_i(a_min), .a_hour_i(a_hour), .a_date_i(a_date),
    .sec_i, .min_i, .hour_i, .date_i,
    .rate_o(rate), .hit_o(hit)
  );

  tod_alarm_irq i_irq (
    .clk_i, .rst_ni, .tick_i, .hit_i(hit), .ae_i(ae), .abe_i(abe),
    .backup_i, .acc_i(flag_acc_i),
    .flag_o(alarm_flag_o), .irq_o(alarm_irq)
  );

  assign irq_no = ~(alarm_irq | wdog_req_i);

  AST_WDOG_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_req_i |-> !irq_no); // R8
  AST_EN_NEEDS_AE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && hit && !ae && !alarm_irq |=> !alarm_irq); // R4
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!alarm_flag_o && !alarm_irq)); // R9
endmodule

// File: tb/test_tod_alarm.sv
module test_tod_alarm;
  logic clk = 0, rst_ni = 0;
  logic tick = 0, we = 0, acc = 0, bkp = 0, wdog = 0;
  logic [6:0] sec = 0, min = 0;
  logic [5:0] hour = 0, date = 0;
  logic [2:0] sel = 0;
  logic [7:0] wdata = 0;
  logic flag, irq_n;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tod_alarm i_tod_alarm (
    .clk_i(clk), .rst_ni, .tick_i(tick), .sec_i(sec), .min_i(min),
    .hour_i(hour), .date_i(date), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .flag_acc_i(acc), .backup_i(bkp),
    .wdog_req_i(wdog), .alarm_flag_o(flag), .irq_no(irq_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); we = 1; sel = s; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic do_tick;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic clear_flags;
    @(negedge clk); acc = 1;
    @(negedge clk); acc = 0;
    @(negedge clk);
  endtask

  function automatic logic exp_hit(input int m, input int t);
    case (m)
      14: return t[0];
      12: return t[0] & t[1];
      8:  return t[0] & t[1] & t[2];
      0:  return t == 15;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 flag", flag, 1'b0);
    chk("R9 irq", irq_n, 1'b1);
    rst_ni = 1;
    @(negedge clk);
    chk("R9 flag after release", flag, 1'b0);
    // R9: zeroed registers mean 0000 mask with all fields 0 -> match
    do_tick;
    chk("R9 zero regs match", flag, 1'b1);
    chk("R4 ae clear keeps irq high", irq_n, 1'b1);
    clear_flags;
    chk("R5 flag clear", flag, 1'b0);

    // R1 R2 R4 sweep all mask patterns against all agreement patterns
    wr(3'd4, 8'h80);
    for (int m = 0; m < 16; m++) begin
      wr(3'd0, 8'h30 | (m[0] ? 8'h80 : 8'h00));
      wr(3'd1, 8'h15 | (m[1] ? 8'h80 : 8'h00));
      wr(3'd2, 8'h12 | (m[2] ? 8'h80 : 8'h00));
      wr(3'd3, 8'h25 | (m[3] ? 8'h80 : 8'h00));
      for (int t = 0; t < 16; t++) begin
        logic e;
        sec  = t[0] ? 7'h30 : 7'h31;
        min  = t[1] ? 7'h15 : 7'h16;
        hour = t[2] ? 6'h12 : 6'h13;
        date = t[3] ? 6'h25 : 6'h26;
        e = exp_hit(m, t);
        do_tick;
        if (m inside {15, 14, 12, 8, 0}) chk("R1 rate flag", flag, e);
        else chk("R2 fallback flag", flag, e);
        chk("R4 irq", irq_n, ~e);
        if (e) clear_flags;
      end
    end

    // R3: matching time without tick leaves flag low
    wr(3'd0, 8'h80); wr(3'd1, 8'h80); wr(3'd2, 8'h80); wr(3'd3, 8'h80);
    repeat (4) @(negedge clk);
    chk("R3 no tick no flag", flag, 1'b0);
    do_tick;
    chk("R3 tick sets flag", flag, 1'b1);

    // R5 access timing
    @(negedge clk); acc = 1;
    @(negedge clk);
    chk("R5 irq released", irq_n, 1'b1);
    chk("R5 flag held", flag, 1'b1);
    acc = 0;
    @(negedge clk);
    chk("R5 flag cleared after access", flag, 1'b0);

    // R6 backup gating
    bkp = 1;
    do_tick;
    chk("R6 flag in backup", flag, 1'b1);
    chk("R6 no irq without abe", irq_n, 1'b1);
    clear_flags;
    wr(3'd4, 8'hA0);
    do_tick;
    chk("R6 irq with abe", irq_n, 1'b0);
    clear_flags;

    // R7 power-up transition clears enables
    @(negedge clk); bkp = 0;
    @(negedge clk);
    do_tick;
    chk("R7 flag still set", flag, 1'b1);
    chk("R7 enables cleared", irq_n, 1'b1);
    clear_flags;

    // R8 watchdog OR
    wdog = 1; @(negedge clk);
    chk("R8 wdog drives irq", irq_n, 1'b0);
    wdog = 0; @(negedge clk);
    chk("R8 wdog release", irq_n, 1'b1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule